// File: doc/BRIEF.md
# Rounding Unit with Compound Significand Adder

This block finishes a floating-point addition by choosing the rounded significand from several candidate sums. Every candidate is built in parallel: the plain sum of the two aligned significands, that sum plus one and that sum plus two. Rounding then becomes a multiplexer choice. There is no incrementer after the adder. The choice depends on four things: the rounding mode, the sign of the result, the result LSB, and the guard, round and sticky bits from alignment.

When the raw sum carries out of the significand width, the rounding position moves up by one bit. The carry is known from the plain sum, before any rounding. The block then uses sum bit 1 as the LSB and sum bit 0 as the guard. The old guard becomes the round bit, and the old round and sticky bits merge into sticky. Rounding up at that position adds two, so the block selects sum plus two.

The chosen value is shifted right so that it fits the significand width. The shift count goes out on `renorm` so that the exponent logic can add it to the exponent. An optional output register adds one cycle of latency.

Top module: `cr_round_unit`

## Requirements
- R1: In the same cycle, the unit forms the sum S, S+1 and S+2 of `sig_a` and `sig_b`. The output is always one of these candidates, shifted right by `renorm`.
- R2: `rmode` = 0 is round to nearest. The unit takes the incremented candidate when guard is 1 and at least one of LSB, round or sticky is 1. Otherwise it keeps S.
- R3: In round to nearest, an exact half-way case (guard 1, round 0, sticky 0) rounds up only when the LSB is 1, so the result is even.
- R4: `rmode` = 1 is round toward zero. It always truncates, whatever the sign or the discarded bits.
- R5: `rmode` = 2 is round toward plus infinity. With `res_sign` = 0, it increments when any discarded bit is 1. With `res_sign` = 1, it truncates.
- R6: `rmode` = 3 is round toward minus infinity. With `res_sign` = 1, it increments when any discarded bit is 1. With `res_sign` = 0, it truncates.
- R7: `inexact` is 1 exactly when a discarded bit at the final rounding position is 1. With no carry, that means guard, round or sticky. With a carry, sum bit 0 also counts.
- R8: When no discarded bit is 1 and S does not carry out, the output equals S, `renorm` is 0 and `inexact` is 0, in every mode.
- R9: When S carries out of the width (S ≥ 2^W), rounding happens at sum bit 1 and an increment selects S+2. The output is the selected value shifted right by one, and `renorm` = 1. The same shift of one, with `renorm` = 1, applies when S+1 reaches 2^W without a raw carry.
- R10: When the selected value reaches 2^(W+1), `renorm` = 2 and the output is that value shifted right by two. Whenever `renorm` is nonzero, output bit W-1 is 1. `renorm` never equals 3.
- R11: With `OUT_REG` = 1, the outputs appear one clock after the inputs. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_a | input | W | First aligned significand |
| sig_b | input | W | Second aligned significand |
| res_sign | input | 1 | Sign of the result (1 = negative) |
| rmode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| grd_in | input | 1 | Guard bit from alignment |
| rnd_in | input | 1 | Round bit from alignment |
| stk_in | input | 1 | Sticky bit from alignment |
| sig_out | output | W | Rounded, renormalized significand |
| renorm | output | 2 | Right-shift count applied, for the exponent increment |
| inexact | output | 1 | Some discarded bit was nonzero |

## Verification
Directed vectors hold the LSB fixed and step through the guard, round and sticky combinations. In round to nearest, these separate a true tie that rounds to even from a tie that rounds away and from a value below half. Every directed mode is tried with both signs, which shows whether the mode test and the sign test are wired together correctly.

Sums that carry out test whether the rounding position moves and whether S+2 is selected, not S+1. Two further patterns cover the renormalize paths: all-ones operands and an all-ones sum plus one. Many random vectors in every mode are then compared against a behavioural model that works by integer division of the scaled value.

// File: rtl/cr_pkg.sv
package cr_pkg;
    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_POSINF  = 2'd2,
        RM_NEGINF  = 2'd3
    } rmode_e;
endpackage

// File: rtl/cr_compound_add.sv
module cr_compound_add #(
    parameter int W = 24
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W:0]   sum0,
    output logic [W:0]   sum1,
    output logic [W+1:0] sum2
);
    localparam int SW = W + 2;

    logic [SW-1:0] ext_a, ext_b;

    always_comb begin
        ext_a = {2'b00, op_a};
        ext_b = {2'b00, op_b};
    end

    logic [SW-1:0] t0, t1, t2;

    // three independent adders, differing only in their carry-in weight
    always_comb begin
        t0   = ext_a + ext_b;
        t1   = ext_a + ext_b + SW'(1);
        t2   = ext_a + ext_b + SW'(2);
        sum0 = t0[W:0];
        sum1 = t1[W:0];
        sum2 = t2;
    end

    logic unused_hi;
    assign unused_hi = t0[W+1] ^ t1[W+1];
endmodule

// File: rtl/cr_round_decide.sv
module cr_round_decide
    import cr_pkg::*;
(
    input  rmode_e mode,
    input  logic   neg,
    input  logic   lsb,
    input  logic   g,
    input  logic   r,
    input  logic   s,
    output logic   bump
);
    logic any_lost;
    assign any_lost = g | r | s;

    always_comb begin
        unique case (mode)
            RM_NEAREST: bump = g & (lsb | r | s);
            RM_ZERO:    bump = 1'b0;
            RM_POSINF:  bump = ~neg & any_lost;
            RM_NEGINF:  bump = neg & any_lost;
            default:    bump = 1'b0;
        endcase
    end
endmodule

// File: rtl/cr_select_norm.sv
module cr_select_norm #(
    parameter int W = 24
) (
    input  logic [W:0]   sum0,
    input  logic [W:0]   sum1,
    input  logic [W+1:0] sum2,
    input  logic         carry,
    input  logic         bump,
    output logic [W-1:0] res,
    output logic [1:0]   shamt
);
    logic [W+1:0] pick;

    always_comb begin
        if (!bump)
            pick = {1'b0, sum0};
        else if (carry)
            pick = sum2;
        else
            pick = {1'b0, sum1};
    end

    always_comb begin
        if (pick[W+1]) begin
            shamt = 2'd2;
            res   = pick[W+1:2];
        end else if (pick[W]) begin
            shamt = 2'd1;
            res   = pick[W:1];
        end else begin
            shamt = 2'd0;
            res   = pick[W-1:0];
        end
    end
endmodule

// File: rtl/cr_round_unit.sv
module cr_round_unit
    import cr_pkg::*;
#(
    parameter int W       = 24,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_a,
    input  logic [W-1:0] sig_b,
    input  logic         res_sign,
    input  logic [1:0]   rmode,
    input  logic         grd_in,
    input  logic         rnd_in,
    input  logic         stk_in,
    output logic [W-1:0] sig_out,
    output logic [1:0]   renorm,
    output logic         inexact
);
    logic [W:0]   s0, s1;
    logic [W+1:0] s2;

    cr_compound_add #(.W(W)) u_add (
        .op_a(sig_a), .op_b(sig_b), .sum0(s0), .sum1(s1), .sum2(s2)
    );

    // rounding position moves up one bit when the raw sum carries out
    logic cy, p_lsb, p_g, p_r, p_s;
    always_comb begin
        cy = s0[W];
        if (cy) begin
            p_lsb = s0[1];
            p_g   = s0[0];
            p_r   = grd_in;
            p_s   = rnd_in | stk_in;
        end else begin
            p_lsb = s0[0];
            p_g   = grd_in;
            p_r   = rnd_in;
            p_s   = stk_in;
        end
    end

    logic bump;
    cr_round_decide u_dec (
        .mode(rmode_e'(rmode)), .neg(res_sign), .lsb(p_lsb),
        .g(p_g), .r(p_r), .s(p_s), .bump(bump)
    );

    logic [W-1:0] n_res;
    logic [1:0]   n_sh;
    cr_select_norm #(.W(W)) u_sel (
        .sum0(s0), .sum1(s1), .sum2(s2), .carry(cy), .bump(bump),
        .res(n_res), .shamt(n_sh)
    );

    logic n_inx;
    assign n_inx = p_g | p_r | p_s;

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sig_out <= '0;
                    renorm  <= '0;
                    inexact <= 1'b0;
                end else begin
                    sig_out <= n_res;
                    renorm  <= n_sh;
                    inexact <= n_inx;
                end
            end
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk;
            always_comb begin
                sig_out = rst_n ? n_res : '0;
                renorm  = rst_n ? n_sh  : '0;
                inexact = rst_n & n_inx;
            end
        end
    endgenerate
endmodule

// File: rtl/cr_round_unit_chk.sv
module cr_round_unit_chk #(
    parameter int W       = 24,
    parameter bit OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] sig_a,
    input logic [W-1:0] sig_b,
    input logic         res_sign,
    input logic [1:0]   rmode,
    input logic         grd_in,
    input logic         rnd_in,
    input logic         stk_in,
    input logic [W-1:0] sig_out,
    input logic [1:0]   renorm,
    input logic         inexact
);
    logic [W-1:0] d_a, d_b;
    logic [1:0]   d_m;
    logic         d_sg, d_g, d_r, d_s, armed;

    generate
        if (OUT_REG) begin : g_dly
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    d_a <= '0; d_b <= '0; d_m <= '0;
                    d_sg <= 1'b0; d_g <= 1'b0; d_r <= 1'b0; d_s <= 1'b0;
                    armed <= 1'b0;
                end else begin
                    d_a <= sig_a; d_b <= sig_b; d_m <= rmode;
                    d_sg <= res_sign; d_g <= grd_in; d_r <= rnd_in; d_s <= stk_in;
                    armed <= 1'b1;
                end
            end
        end else begin : g_now
            always_comb begin
                d_a = sig_a; d_b = sig_b; d_m = rmode; d_sg = res_sign;
                d_g = grd_in; d_r = rnd_in; d_s = stk_in; armed = 1'b1;
            end
        end
    endgenerate

    logic [W:0] d_sum;
    assign d_sum = {1'b0, d_a} + {1'b0, d_b};

    a_r8_exact_passthru: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!d_g && !d_r && !d_s && !d_sum[W]) |-> (sig_out == d_sum[W-1:0] && renorm == 2'd0 && !inexact));

    a_r7_inexact_seen: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (d_g || d_r || d_s) |-> inexact);

    a_r4_rtz_truncates: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (d_m == 2'd1 && !d_sum[W]) |-> (sig_out == d_sum[W-1:0] && renorm == 2'd0));

    // R5 and R6: directed mode against the sign of the result never rounds
    a_r5_r6_wrong_sign_keeps: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (((d_m == 2'd2 && d_sg) || (d_m == 2'd3 && !d_sg)) && !d_sum[W]) |-> (sig_out == d_sum[W-1:0]));

    a_r10_lead_one: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (renorm != 2'd0) |-> sig_out[W-1]);

    a_r10_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
        renorm != 2'd3);
endmodule

bind cr_round_unit cr_round_unit_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_cr_round_unit.sv
`timescale 1ns/1ps
module sim_cr_round_unit;
    localparam int W = 24;
    localparam longint ONE = 64'd1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [W-1:0] sig_a = '0, sig_b = '0;
    logic res_sign = 1'b0, grd_in = 1'b0, rnd_in = 1'b0, stk_in = 1'b0;
    logic [1:0] rmode = 2'd0;
    logic [W-1:0] sig_out;
    logic [1:0] renorm;
    logic inexact;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    cr_round_unit u0 (.clk(clk), .rst_n(rst_n), .sig_a(sig_a), .sig_b(sig_b),
        .res_sign(res_sign), .rmode(rmode), .grd_in(grd_in), .rnd_in(rnd_in),
        .stk_in(stk_in), .sig_out(sig_out), .renorm(renorm), .inexact(inexact));

    // behavioural model: scale by 8, divide at the rounding unit
    task automatic model(input longint a, input longint b, input bit sg, input int m,
                         input bit g, input bit r, input bit s,
                         output longint o, output int sh, output bit ix);
        longint sum = a + b;
        int k = (sum >= (ONE << W)) ? 1 : 0;
        longint full = sum * 8 + g * 4 + r * 2 + s;
        longint unit = longint'(8) << k;
        longint kept = full / unit;
        longint rem = full % unit;
        longint half = unit / 2;
        longint sel;
        bit up;
        case (m)
            0: up = (rem > half) || (rem == half && kept % 2 == 1);
            1: up = 0;
            2: up = (rem != 0) && !sg;
            default: up = (rem != 0) && sg;
        endcase
        sel = (kept + (up ? 1 : 0)) << k;
        sh = (sel >= (ONE << (W + 1))) ? 2 : (sel >= (ONE << W)) ? 1 : 0;
        o = sel >> sh;
        ix = rem != 0;
    endtask

    task automatic apply(input string req, input longint a, input longint b, input bit sg,
                         input int m, input bit g, input bit r, input bit s);
        longint eo; int esh; bit eix;
        @(negedge clk);
        sig_a = a[W-1:0]; sig_b = b[W-1:0]; res_sign = sg; rmode = m[1:0];
        grd_in = g; rnd_in = r; stk_in = s;
        model(a, b, sg, m, g, r, s, eo, esh, eix);
        @(posedge clk); #2;
        checks++;
        if (longint'(sig_out) != eo || int'(renorm) != esh || inexact != eix) begin
            errors++;
            $display("FAIL %s: got out=%h sh=%0d ix=%0d expected out=%h sh=%0d ix=%0d",
                     req, sig_out, renorm, inexact, eo, esh, eix);
        end
    endtask

    initial begin
        #100000000;
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam longint H = ONE << (W - 1);
    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (sig_out != '0 || renorm != 2'd0 || inexact != 1'b0) begin
            errors++;
            $display("FAIL R11 reset: got %h/%0d/%0d expected 0/0/0", sig_out, renorm, inexact);
        end
        @(negedge clk); rst_n = 1'b1;
        apply("R3 tie even stays", H, 2, 0, 0, 1, 0, 0);
        apply("R3 tie odd rounds", H, 3, 0, 0, 1, 0, 0);
        apply("R2 above half", H, 2, 0, 0, 1, 0, 1);
        apply("R2 below half", H, 3, 0, 0, 0, 1, 1);
        apply("R4 toward zero", H, 3, 1, 1, 1, 1, 1);
        apply("R5 plus inf positive", H, 2, 0, 2, 0, 0, 1);
        apply("R5 plus inf negative", H, 2, 1, 2, 1, 1, 1);
        apply("R6 minus inf negative", H, 2, 1, 3, 0, 1, 0);
        apply("R6 minus inf positive", H, 2, 0, 3, 1, 0, 0);
        apply("R8 exact", H, 12345, 1, 2, 0, 0, 0);
        apply("R9 carry tie even", 64'hC00000, 64'hC00001, 0, 0, 0, 0, 0);
        apply("R9 carry round S+2", 64'hC00000, 64'hC00003, 0, 0, 0, 0, 0);
        apply("R9 S+1 overflow", 64'h800000, 64'h7FFFFF, 0, 0, 1, 1, 0);
        apply("R10 double renorm", 64'hFFFFFF, 64'hFFFFFF, 0, 2, 1, 0, 0);
        apply("R7 carry drops bit0", 64'hC00000, 64'hC00001, 0, 1, 0, 0, 0);
        for (int i = 0; i < 400; i++) begin
            longint ra = longint'($urandom) & ((ONE << W) - 1);
            longint rb = longint'($urandom) & ((ONE << W) - 1);
            int rm = int'($urandom % 4);
            apply("R1 random", ra, rb, 1'($urandom), rm, 1'($urandom), 1'($urandom), 1'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule